// File: doc/BRIEF.md
# Converter Result Output Port

This block is the digital output stage of a 16-bit converter. It takes a finished conversion word, which arrives in offset-binary form, and makes it available to a host in one of two ways. In parallel mode a registered 16-bit bus carries the word, and its two bytes can be exchanged. In serial mode a shift register sends the word out on a single data line, clocked by a shift clock from the host. A chain input lets several converters share one serial line. The output can be kept in offset binary or changed to two's complement by inverting the top bit. The block also handles the conversion-request handshake: it tracks a conversion in progress, aborts it on reset, and refuses requests until an acquisition delay has passed after reset.

Everything runs on one system clock with a synchronous active-high reset. The shift clock is sampled through two flops and its edges are found from the sampled copy. A shift clock edge therefore changes the shift state on the second system clock after the edge, and the serial pin shows the change one clock after that. Each tri-state output is modelled as a data value plus an enable. While an enable is low the matching data output is driven to zero.

Top module: `adc_out_port`

## Requirements
- R1: par_oe goes high one clock after a cycle in which ser_sel, chip_sel_n and read_n are all low, and is low otherwise.
- R2: When par_oe is high and swap_bytes is low, par_data[15:8] holds bits 15..8 of the coded result and par_data[7:0] holds bits 7..0. When swap_bytes is high the two bytes trade places. The change appears one clock after swap_bytes changes.
- R3: ser_oe goes high one clock after a cycle in which ser_sel is high and chip_sel_n and read_n are both low. par_oe and ser_oe are never high together, so the parallel bus is undriven in serial mode.
- R4: After a result is loaded, bit 15 is on ser_out. Rising shift-clock edges that come before the first falling edge do not shift. Each rising edge after the first falling edge moves the next lower bit onto ser_out.
- R5: On each falling shift-clock edge, chain_in is captured, and it enters the register at the LSB on the next qualified rising edge. The bit captured on the first falling edge reaches ser_out after the sixteenth qualified rising edge, so a downstream receiver samples it on the seventeenth falling edge.
- R6: With offset_fmt high, the result is passed unchanged. With offset_fmt low, bit 15 is inverted to give two's complement. This applies to the parallel bus (using the live offset_fmt) and to the word loaded into the shift register (using offset_fmt at load time).
- R7: res_valid is accepted only while conv_busy is high. It clears conv_busy, stores res_word and reloads the shift register. res_valid while idle changes nothing.
- R8: While rst is high, conv_busy drops (aborting the conversion), both enables go low, conv_req is ignored and the stored result clears to zero.
- R9: After rst falls, conv_req is refused for ACQ_CYCLES clocks. With the default of 8, a request held from release is first accepted on the ninth clock. An accepted request raises conv_busy and pulses conv_start for one clock.
- R10: While chip_sel_n is high, ser_oe is low and shift-clock edges neither shift nor capture. The serial position is kept for when chip_sel_n returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Conversion request |
| res_word | input | 16 | Offset-binary conversion result |
| res_valid | input | 1 | Result strobe, taken while busy |
| ser_sel | input | 1 | High selects serial mode, low selects parallel mode |
| chip_sel_n | input | 1 | Active-low chip select |
| read_n | input | 1 | Active-low read enable |
| swap_bytes | input | 1 | Exchange the bytes on the parallel bus |
| offset_fmt | input | 1 | High for offset binary, low for two's complement |
| shift_clk | input | 1 | Serial shift clock from the host |
| chain_in | input | 1 | Serial data from an upstream device |
| par_data | output | 16 | Parallel data |
| par_oe | output | 1 | Parallel bus drive enable |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Serial pin drive enable |
| conv_start | output | 1 | One-clock pulse when a request is accepted |
| conv_busy | output | 1 | Conversion in progress |

## Verification
The hardest state to reach from the ports is a daisy chain deep enough that upstream bits reach the MSB. The stimulus loads a known word, toggles the shift clock through thirty-two full periods, and changes chain_in only at rising edges. This checks all sixteen local bits and all sixteen chained bits, including the boundary at the seventeenth period. The other hard cases are a reset pulse while a conversion is open, followed by a late result strobe, and a request held high from the release of reset to find the exact acceptance clock. Chip select is also raised partway through a serial word to show that the position is kept.

// File: rtl/adc_out_pkg.sv
`timescale 1ns/1ps
package adc_out_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_PAR = 2'd1,
    MODE_SER = 2'd2
  } port_mode_e;

  function automatic port_mode_e pick_mode(input logic ser_sel,
                                           input logic chip_sel_n,
                                           input logic read_n);
    if (chip_sel_n || read_n) return MODE_OFF;
    return ser_sel ? MODE_SER : MODE_PAR;
  endfunction

endpackage

// File: rtl/adc_acq_ctrl.sv
`timescale 1ns/1ps
module adc_acq_ctrl #(
  parameter int ACQ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_req,
  input  logic res_valid,
  output logic conv_start,
  output logic conv_busy,
  output logic take_result
);
  localparam int CNT_W = (ACQ_CYCLES < 1) ? 1 : $clog2(ACQ_CYCLES + 1);

  logic [CNT_W-1:0] acq_cnt;
  logic             acq_done;

  assign acq_done    = (acq_cnt == '0);
  assign take_result = conv_busy && res_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_cnt    <= CNT_W'(ACQ_CYCLES);
      conv_busy  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (!acq_done) acq_cnt <= acq_cnt - CNT_W'(1);
      if (take_result) begin
        conv_busy <= 1'b0;
      end else if (!conv_busy && acq_done && conv_req) begin
        conv_busy  <= 1'b1;
        conv_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_word_format.sv
`timescale 1ns/1ps
module adc_word_format #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         offset_fmt,
  input  logic         swap_bytes,
  output logic [W-1:0] bus
);
  localparam int H = W / 2;

  logic [W-1:0] coded;

  assign coded = offset_fmt ? raw : {~raw[W-1], raw[W-2:0]};

  generate
    if (W % 2 == 0) begin : g_swap
      assign bus = swap_bytes ? {coded[H-1:0], coded[W-1:H]} : coded;
    end else begin : g_noswap
      logic unused_swap;
      assign unused_swap = swap_bytes;
      assign bus = coded;
    end
  endgenerate
endmodule

// File: rtl/adc_ser_shift.sv
`timescale 1ns/1ps
module adc_ser_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         active,
  input  logic         edge_rise,
  input  logic         edge_fall,
  input  logic         chain_in,
  output logic         msb
);
  logic [W-1:0] sreg;
  logic         armed;
  logic         pend;

  assign msb = sreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (load) begin
      sreg  <= load_word;
      armed <= 1'b0;
    end else if (active) begin
      if (edge_fall) begin
        pend  <= chain_in;
        armed <= 1'b1;
      end
      if (edge_rise && armed) sreg <= {sreg[W-2:0], pend};
    end
  end
endmodule

// File: rtl/adc_out_port.sv
`timescale 1ns/1ps
module adc_out_port
  import adc_out_pkg::*;
#(
  parameter int W          = 16,
  parameter int ACQ_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_req,
  input  logic [W-1:0] res_word,
  input  logic         res_valid,
  input  logic         ser_sel,
  input  logic         chip_sel_n,
  input  logic         read_n,
  input  logic         swap_bytes,
  input  logic         offset_fmt,
  input  logic         shift_clk,
  input  logic         chain_in,
  output logic [W-1:0] par_data,
  output logic         par_oe,
  output logic         ser_out,
  output logic         ser_oe,
  output logic         conv_start,
  output logic         conv_busy
);
  port_mode_e   mode;
  logic         take_result;
  logic [W-1:0] res_q;
  logic [W-1:0] par_word;
  logic [W-1:0] load_word;
  logic         sclk_s1, sclk_s2;
  logic         edge_rise, edge_fall;
  logic         shift_msb;

  assign mode      = pick_mode(ser_sel, chip_sel_n, read_n);
  assign edge_rise = sclk_s1 && !sclk_s2;
  assign edge_fall = !sclk_s1 && sclk_s2;

  adc_acq_ctrl #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk        (clk),
    .rst        (rst),
    .conv_req   (conv_req),
    .res_valid  (res_valid),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .take_result(take_result)
  );

  adc_word_format #(.W(W)) u_fmt_par (
    .raw       (res_q),
    .offset_fmt(offset_fmt),
    .swap_bytes(swap_bytes),
    .bus       (par_word)
  );

  adc_word_format #(.W(W)) u_fmt_load (
    .raw       (res_word),
    .offset_fmt(offset_fmt),
    .swap_bytes(1'b0),
    .bus       (load_word)
  );

  adc_ser_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (take_result),
    .load_word(load_word),
    .active   (mode == MODE_SER),
    .edge_rise(edge_rise),
    .edge_fall(edge_fall),
    .chain_in (chain_in),
    .msb      (shift_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= '0;
      sclk_s1  <= 1'b0;
      sclk_s2  <= 1'b0;
      par_data <= '0;
      par_oe   <= 1'b0;
      ser_out  <= 1'b0;
      ser_oe   <= 1'b0;
    end else begin
      sclk_s1  <= shift_clk;
      sclk_s2  <= sclk_s1;
      if (take_result) res_q <= res_word;
      par_oe   <= (mode == MODE_PAR);
      par_data <= (mode == MODE_PAR) ? par_word : '0;
      ser_oe   <= (mode == MODE_SER);
      ser_out  <= (mode == MODE_SER) ? shift_msb : 1'b0;
    end
  end
endmodule

// File: rtl/adc_out_port_chk.sv
`timescale 1ns/1ps
module adc_out_port_chk (
  input logic clk,
  input logic rst,
  input logic conv_req,
  input logic res_valid,
  input logic ser_sel,
  input logic chip_sel_n,
  input logic read_n,
  input logic par_oe,
  input logic ser_oe,
  input logic conv_start,
  input logic conv_busy
);
  assert_par_enable_R1: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> $past(!ser_sel && !chip_sel_n && !read_n));

  assert_ser_enable_R3: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> $past(ser_sel && !chip_sel_n && !read_n));

  assert_single_driver_R3: assert property (@(posedge clk) disable iff (rst)
    !(par_oe && ser_oe));

  assert_cs_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    $past(chip_sel_n) |-> (!ser_oe && !par_oe));

  assert_reset_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!par_oe && !ser_oe && !conv_busy));

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(!conv_busy && conv_req));

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_busy) |-> ($past(res_valid) || $past(rst)));
endmodule

bind adc_out_port adc_out_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .conv_req  (conv_req),
  .res_valid (res_valid),
  .ser_sel   (ser_sel),
  .chip_sel_n(chip_sel_n),
  .read_n    (read_n),
  .par_oe    (par_oe),
  .ser_oe    (ser_oe),
  .conv_start(conv_start),
  .conv_busy (conv_busy)
);

// File: tb/tb_adc_out_port.sv
`timescale 1ns/1ps
module tb_adc_out_port;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, conv_req = 1'b0, res_valid = 1'b0;
  logic        ser_sel = 1'b0, chip_sel_n = 1'b1, read_n = 1'b1;
  logic        swap_bytes = 1'b0, offset_fmt = 1'b1, shift_clk = 1'b0, chain_in = 1'b0;
  logic [15:0] res_word = 16'h0;
  logic [15:0] par_data;
  logic        par_oe, ser_out, ser_oe, conv_start, conv_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  adc_out_port dut (
    .clk(clk), .rst(rst), .conv_req(conv_req), .res_word(res_word),
    .res_valid(res_valid), .ser_sel(ser_sel), .chip_sel_n(chip_sel_n),
    .read_n(read_n), .swap_bytes(swap_bytes), .offset_fmt(offset_fmt),
    .shift_clk(shift_clk), .chain_in(chain_in), .par_data(par_data),
    .par_oe(par_oe), .ser_out(ser_out), .ser_oe(ser_oe),
    .conv_start(conv_start), .conv_busy(conv_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(input int v, input bit ob);
    return ob ? v : (v ^ 32768);
  endfunction

  function automatic int swap_of(input int v, input bit sw);
    return sw ? (((v % 256) * 256) + (v / 256)) : v;
  endfunction

  // behavioural reference model, advanced on each rising clock edge
  int m_acq, m_res, m_code;
  bit m_busy, m_armed, m_pend, m_s1, m_s2, model_ok;
  bit m_q[$];
  bit e_par_oe, e_ser_oe, e_ser_out, e_start, e_busy;
  int e_par_data;
  bit m_rise, m_fall, m_take, m_ready, m_pen, m_sen;

  always @(posedge clk) begin
    m_rise = m_s1 && !m_s2;
    m_fall = !m_s1 && m_s2;
    if (rst) begin
      m_acq = 8; m_busy = 0; m_res = 0; m_armed = 0; m_pend = 0;
      m_q.delete();
      repeat (16) m_q.push_back(1'b0);
      e_par_oe = 0; e_ser_oe = 0; e_ser_out = 0; e_start = 0; e_busy = 0; e_par_data = 0;
      m_s1 = 0; m_s2 = 0;
    end else begin
      m_pen = !ser_sel && !chip_sel_n && !read_n;
      m_sen = ser_sel && !chip_sel_n && !read_n;
      e_par_oe   = m_pen;
      e_par_data = m_pen ? swap_of(code_of(m_res, offset_fmt), swap_bytes) : 0;
      e_ser_oe   = m_sen;
      e_ser_out  = m_sen ? m_q[0] : 1'b0;
      m_ready = (m_acq == 0);
      if (m_acq > 0) m_acq--;
      m_take = m_busy && res_valid;
      e_start = 0;
      if (m_take) begin
        m_busy = 0;
        m_res  = int'(res_word);
      end else if (!m_busy && m_ready && conv_req) begin
        m_busy  = 1;
        e_start = 1;
      end
      e_busy = m_busy;
      if (m_take) begin
        m_code = code_of(int'(res_word), offset_fmt);
        m_q.delete();
        for (int i = 15; i >= 0; i--) m_q.push_back(m_code[i]);
        m_armed = 0;
      end else if (m_sen) begin
        if (m_fall) begin
          m_pend  = chain_in;
          m_armed = 1;
        end
        if (m_rise && m_armed) begin
          void'(m_q.pop_front());
          m_q.push_back(m_pend);
        end
      end
      m_s2 = m_s1;
      m_s1 = shift_clk;
    end
    model_ok = 1;
  end

  always @(negedge clk) begin
    if (model_ok && !finished) begin
      chk("R1 model par_oe", int'(par_oe), int'(e_par_oe));
      chk("R2 R6 model par_data", int'(par_data), e_par_data);
      chk("R3 R10 model ser_oe", int'(ser_oe), int'(e_ser_oe));
      chk("R4 R5 model ser_out", int'(ser_out), int'(e_ser_out));
      chk("R7 R8 model conv_busy", int'(conv_busy), int'(e_busy));
      chk("R9 model conv_start", int'(conv_start), int'(e_start));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_conv(input logic [15:0] w);
    conv_req = 1'b1;
    step(1);
    conv_req  = 1'b0;
    res_word  = w;
    res_valid = 1'b1;
    step(1);
    res_valid = 1'b0;
    step(2);
  endtask

  task automatic sclk_cycle();
    shift_clk = 1'b1;
    step(3);
    shift_clk = 1'b0;
    step(3);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [15:0] D_WORD = 16'hA5C3;
  localparam logic [15:0] C_WORD = 16'h6E91;

  initial begin
    step(3);
    @(negedge clk);
    chk("R8 reset par_oe", int'(par_oe), 0);
    chk("R8 reset ser_oe", int'(ser_oe), 0);
    step(1);
    rst = 1'b0;
    step(1);
    conv_req = 1'b1;
    step(1);
    conv_req = 1'b0;
    @(negedge clk);
    chk("R9 request during acquisition", int'(conv_busy), 0);
    step(10);

    // parallel mode, byte order and coding
    chip_sel_n = 1'b0; read_n = 1'b0; ser_sel = 1'b0;
    do_conv(16'h1234);
    @(negedge clk);
    chk("R1 par_oe on", int'(par_oe), 1);
    chk("R2 straight", int'(par_data), 16'h1234);
    step(1);
    swap_bytes = 1'b1;
    step(1);
    @(negedge clk);
    chk("R2 swapped", int'(par_data), 16'h3412);
    step(1);
    offset_fmt = 1'b0;
    step(1);
    @(negedge clk);
    chk("R6 swapped twos", int'(par_data), 16'h3492);
    step(1);
    swap_bytes = 1'b0;
    step(1);
    @(negedge clk);
    chk("R6 twos", int'(par_data), 16'h9234);
    step(1);
    read_n = 1'b1;
    step(1);
    @(negedge clk);
    chk("R1 read high off", int'(par_oe), 0);
    step(1);

    // serial mode with chained data
    read_n = 1'b0; ser_sel = 1'b1; offset_fmt = 1'b1;
    do_conv(D_WORD);
    @(negedge clk);
    chk("R3 par off in serial", int'(par_oe), 0);
    chk("R3 ser_oe on", int'(ser_oe), 1);
    chk("R4 msb first", int'(ser_out), int'(D_WORD[15]));
    for (int k = 0; k < 32; k++) begin
      step(1);
      shift_clk = 1'b1;
      chain_in  = (k < 16) ? C_WORD[15-k] : 1'b0;
      step(3);
      @(negedge clk);
      if (k < 16) chk("R4 local bit", int'(ser_out), int'(D_WORD[15-k]));
      else        chk("R5 chained bit", int'(ser_out), int'(C_WORD[31-k]));
      step(1);
      shift_clk = 1'b0;
      step(3);
    end

    // chip select held high in the middle of a word
    offset_fmt = 1'b0;
    do_conv(16'h9A00);
    @(negedge clk);
    chk("R6 serial load twos msb", int'(ser_out), 0);
    step(1);
    repeat (4) sclk_cycle();
    @(negedge clk);
    chk("R4 after three shifts", int'(ser_out), 1);
    step(1);
    chip_sel_n = 1'b1;
    step(2);
    @(negedge clk);
    chk("R10 ser_oe off", int'(ser_oe), 0);
    step(1);
    repeat (2) sclk_cycle();
    chip_sel_n = 1'b0;
    step(3);
    @(negedge clk);
    chk("R10 position held", int'(ser_out), 1);
    step(1);
    sclk_cycle();
    @(negedge clk);
    chk("R10 shift resumes", int'(ser_out), 1);
    step(1);
    sclk_cycle();
    @(negedge clk);
    chk("R4 next bit", int'(ser_out), 0);

    // reset aborts an open conversion
    step(1);
    ser_sel = 1'b0; offset_fmt = 1'b1;
    conv_req = 1'b1;
    step(1);
    conv_req = 1'b0;
    @(negedge clk);
    chk("R9 accepted", int'(conv_busy), 1);
    step(1);
    rst = 1'b1;
    conv_req = 1'b1;
    step(2);
    @(negedge clk);
    chk("R8 busy aborted", int'(conv_busy), 0);
    chk("R8 bus hiz", int'(par_oe), 0);
    step(1);
    rst = 1'b0;
    conv_req = 1'b0;
    res_word = 16'hFFFF;
    res_valid = 1'b1;
    step(1);
    res_valid = 1'b0;
    step(2);
    @(negedge clk);
    chk("R8 R7 late result dropped", int'(par_data), 16'h0000);

    // exact acquisition boundary after reset
    step(1);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    conv_req = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      step(1);
      @(negedge clk);
      chk("R9 acquisition boundary", int'(conv_busy), (i == 9) ? 1 : 0);
      if (i == 9) chk("R9 start pulse", int'(conv_start), 1);
    end
    step(1);
    conv_req = 1'b0;
    @(negedge clk);
    chk("R9 start one clock", int'(conv_start), 0);
    step(1);
    res_word = 16'h0001;
    res_valid = 1'b1;
    step(1);
    res_valid = 1'b0;
    step(2);
    @(negedge clk);
    chk("R7 result taken", int'(par_data), 16'h0001);
    step(1);
    res_word = 16'hBEEF;
    res_valid = 1'b1;
    step(1);
    res_valid = 1'b0;
    step(2);
    @(negedge clk);
    chk("R7 idle strobe ignored", int'(par_data), 16'h0001);
    step(2);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule